// File: doc/BRIEF.md
# Translation Lookaside Buffer with Global Entries

This block is a small fully-associative cache holding linear-to-physical page translations for a 32-bit address space with 4 KiB pages. A lookup presents a linear address and a 4-bit access code. It returns a hit with the translated physical address in the same cycle, or a miss. When the miss is caused by a matching entry whose flags refuse the access, the block also raises a fault flag. The core then calls the page walker, which either refills the entry (for example, to set the dirty bit) or raises a page fault.

Each entry keeps a 32-bit tag word and a 20-bit physical frame number. The tag word holds the linear page number in bits 31:12 and the status flags in its low bits:
- valid at bit 0;
- writable at bit 1, the AND of the directory and table writable bits;
- user at bit 2, the AND of the directory and table user bits;
- dirty at bit 6;
- global at bit 8.

The walker fills entries. Software-visible events remove them: a single-page invalidate, a flush that keeps global entries (issued when the directory base register is written), or a flush of everything.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, every lookup misses with the fault flag low, and the replacement pointer selects entry 0.
- R2: A lookup that hits returns, in the same cycle, the stored 20-bit frame in bits 31:12 of the physical address and the lookup's bits 11:0 in bits 11:0. A miss drives a physical address of zero.
- R3: The access code carries write at bit 0, code fetch at bit 1, data at bit 2 and user mode at bit 3. A fill stores writable as directory-writable AND table-writable, user as directory-user AND table-user, and takes dirty and global from the table entry.
- R4: A user-mode lookup to an entry whose user flag is clear misses and raises the fault flag.
- R5: A write lookup hits only if the entry is both writable and dirty. A write to a read-only page, or to a writable page that is still clean, misses and raises the fault flag.
- R6: A supervisor read or code fetch hits regardless of the user and writable flags. A lookup whose page number matches no valid entry misses with the fault flag low.
- R7: A fill for a page that is not present writes the entry selected by a round-robin pointer. The pointer then advances and wraps from the last entry to entry 0.
- R8: A fill for a page already present overwrites that entry in place, including its frame and flags, and leaves the round-robin pointer unchanged. At most one valid entry ever matches a page.
- R9: An invalidate clears only the entry that matches the given page number.
- R10: A flush with the all-flush input low clears every entry except those with the global flag set.
- R11: A flush with the all-flush input high clears every entry in one cycle.
- R12: A lookup presented in the same cycle as a flush reports a plain miss, with the fault flag low.
- R13: When operations are presented together, only one takes effect: a flush overrides an invalidate, and either of them overrides a fill, which is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Linear address to translate |
| lk_access | input | 4 | Access code: write bit 0, code bit 1, data bit 2, user bit 3 |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | Lookup did not hit |
| lk_fault | output | 1 | Miss caused by a matching entry refusing the access |
| lk_paddr | output | 32 | Translated physical address (zero when not hit) |
| fill_valid | input | 1 | Write a translation from the walker |
| fill_vpn | input | 20 | Linear page number of the fill |
| fill_frame | input | 20 | Physical frame number of the fill |
| fill_dir_wr | input | 1 | Directory entry writable bit |
| fill_dir_user | input | 1 | Directory entry user bit |
| fill_pte_wr | input | 1 | Table entry writable bit |
| fill_pte_user | input | 1 | Table entry user bit |
| fill_pte_dirty | input | 1 | Table entry dirty bit |
| fill_pte_global | input | 1 | Table entry global bit |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Linear page number to invalidate |
| flush_valid | input | 1 | Flush request |
| flush_all | input | 1 | With a flush: high clears global entries too |

## Verification
The hardest state to reach from the ports is the replacement pointer's position after a refill of a page that is already present. The pointer is never visible directly, so its position can only be inferred from which page a later fill evicts. The stimulus first fills every entry so the pointer wraps, then adds one new page, then refills a page that is already present, and then adds another new page. Lookups to all remaining pages then show which slot was replaced, and so whether the refill wrongly moved the pointer. The lookup made during a flush cycle and the fills discarded by a concurrent flush or invalidate are reached by driving those requests on the same clock edge.

// File: rtl/tlb_cache.sv
`timescale 1ns/1ps
module tlb_cache #(
  parameter int ENTRIES = 4,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic [3:0]  lk_access,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic        lk_fault,
  output logic [31:0] lk_paddr,
  input  logic        fill_valid,
  input  logic [19:0] fill_vpn,
  input  logic [19:0] fill_frame,
  input  logic        fill_dir_wr,
  input  logic        fill_dir_user,
  input  logic        fill_pte_wr,
  input  logic        fill_pte_user,
  input  logic        fill_pte_dirty,
  input  logic        fill_pte_global,
  input  logic        inv_valid,
  input  logic [19:0] inv_vpn,
  input  logic        flush_valid,
  input  logic        flush_all
);
  localparam int B_V = 0, B_W = 1, B_U = 2, B_D = 6, B_G = 8;

  logic [31:0] tag_q   [ENTRIES];
  logic [19:0] frame_q [ENTRIES];
  logic [IW-1:0] rr_q;

  logic [ENTRIES-1:0] valid_vec, global_vec, lk_match, perm_ok, fill_match, inv_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign valid_vec[i]  = tag_q[i][B_V];
    assign global_vec[i] = tag_q[i][B_G];
    assign lk_match[i]   = valid_vec[i] && (tag_q[i][31:12] == lk_addr[31:12]);
    assign fill_match[i] = valid_vec[i] && (tag_q[i][31:12] == fill_vpn);
    assign inv_match[i]  = valid_vec[i] && (tag_q[i][31:12] == inv_vpn);
    assign perm_ok[i]    = (!lk_access[3] || tag_q[i][B_U]) &&
                           (!lk_access[0] || (tag_q[i][B_W] && tag_q[i][B_D]));
  end

  wire lk_live = lk_valid && !flush_valid;
  assign lk_hit   = lk_live && |(lk_match & perm_ok);
  assign lk_miss  = lk_valid && !lk_hit;
  assign lk_fault = lk_live && !lk_hit && |lk_match;

  logic [19:0] hit_frame;
  always_comb begin
    hit_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i] && perm_ok[i]) hit_frame = hit_frame | frame_q[i];
  end
  assign lk_paddr = lk_hit ? {hit_frame, lk_addr[11:0]} : 32'h0;

  logic [IW-1:0] match_idx;
  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fill_match[i]) match_idx = IW'(i);
  end
  wire           fill_hit = |fill_match;
  wire [IW-1:0]  wr_idx   = fill_hit ? match_idx : rr_q;
  wire [31:0]    new_tag  = {fill_vpn, 3'b000, fill_pte_global, 1'b0, fill_pte_dirty, 3'b000,
                             fill_dir_user & fill_pte_user, fill_dir_wr & fill_pte_wr, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]   <= '0;
        frame_q[i] <= '0;
      end
      rr_q <= '0;
    end else if (flush_valid) begin
      for (int i = 0; i < ENTRIES; i++)
        if (flush_all || !tag_q[i][B_G]) tag_q[i][B_V] <= 1'b0;
    end else if (inv_valid) begin
      for (int i = 0; i < ENTRIES; i++)
        if (inv_match[i]) tag_q[i][B_V] <= 1'b0;
    end else if (fill_valid) begin
      tag_q[wr_idx]   <= new_tag;
      frame_q[wr_idx] <= fill_frame;
      if (!fill_hit)
        rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R3
  access_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($onehot0(lk_access[2:1]) && !(lk_access[1] && lk_access[0])));

  // R7
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_valid && !inv_valid) |=> valid_vec[$past(wr_idx)]);

  // R8
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R9
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !flush_valid) |=> ((valid_vec & $past(inv_match)) == '0));

  // R10
  flush_keeps_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !flush_all) |=> (valid_vec == $past(valid_vec & global_vec)));

  // R11
  flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_all) |=> (valid_vec == '0));
endmodule

// File: tb/tlb_cache_tb_top.sv
`timescale 1ns/1ps
module tlb_cache_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0; logic [31:0] lk_addr = 0; logic [3:0] lk_access = 0;
  logic lk_hit, lk_miss, lk_fault; logic [31:0] lk_paddr;
  logic fill_valid = 0; logic [19:0] fill_vpn = 0, fill_frame = 0;
  logic fdw = 0, fdu = 0, fpw = 0, fpu = 0, fpd = 0, fpg = 0;
  logic inv_valid = 0; logic [19:0] inv_vpn = 0;
  logic flush_valid = 0, flush_all = 0;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  tlb_cache #(.ENTRIES(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_access(lk_access),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
    .fill_dir_wr(fdw), .fill_dir_user(fdu), .fill_pte_wr(fpw), .fill_pte_user(fpu),
    .fill_pte_dirty(fpd), .fill_pte_global(fpg), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .flush_valid(flush_valid), .flush_all(flush_all));

  typedef struct packed {
    logic [31:0] la; logic [3:0] acc; logic hit; logic flt; logic [31:0] pa;
  } vec_t;
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{32'h0040_1123, 4'h4, 1'b1, 1'b0, 32'h1234_5123},
    '{32'h0040_1FFF, 4'hD, 1'b1, 1'b0, 32'h1234_5FFF},
    '{32'h0080_2010, 4'h2, 1'b1, 1'b0, 32'h0ABC_D010},
    '{32'h0080_2010, 4'hA, 1'b0, 1'b1, 32'h0},
    '{32'h0080_2800, 4'h5, 1'b1, 1'b0, 32'h0ABC_D800},
    '{32'h00C0_32A0, 4'hC, 1'b1, 1'b0, 32'h7777_72A0},
    '{32'h00C0_32A0, 4'h5, 1'b0, 1'b1, 32'h0},
    '{32'h0100_4004, 4'h5, 1'b0, 1'b1, 32'h0},
    '{32'h0100_4004, 4'hA, 1'b1, 1'b0, 32'h5555_5004},
    '{32'h0200_0000, 4'h4, 1'b0, 1'b0, 32'h0},
    '{32'h8040_1000, 4'h4, 1'b0, 1'b0, 32'h0}
  };
  localparam string VREQ [NV] = '{"R2", "R3", "R6", "R4", "R3", "R6", "R5", "R5", "R2", "R6", "R6"};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(string req, logic [31:0] la, logic [3:0] acc, logic eh, logic ef, logic [31:0] epa);
    @(negedge clk);
    lk_valid = 1; lk_addr = la; lk_access = acc;
    #2;
    chk(req, {29'd0, lk_hit, lk_miss, lk_fault}, {29'd0, eh, ~eh, ef});
    chk(req, lk_paddr, eh ? epa : 32'h0);
    lk_valid = 0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] frm, logic dw, logic du, logic pw, logic pu,
                      logic pd, logic pg);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_frame = frm;
    fdw = dw; fdu = du; fpw = pw; fpu = pu; fpd = pd; fpg = pg;
    @(posedge clk); #1 fill_valid = 0;
  endtask

  task automatic inval(logic [19:0] vpn, logic with_fill, logic [19:0] fvpn);
    @(negedge clk);
    inv_valid = 1; inv_vpn = vpn;
    fill_valid = with_fill; fill_vpn = fvpn; fill_frame = 20'hABCDE;
    fdw = 1; fdu = 1; fpw = 1; fpu = 1; fpd = 1; fpg = 0;
    @(posedge clk); #1 inv_valid = 0; fill_valid = 0;
  endtask

  task automatic flush(logic all, logic [31:0] la, logic with_fill, logic [19:0] fvpn);
    @(negedge clk);
    flush_valid = 1; flush_all = all;
    lk_valid = 1; lk_addr = la; lk_access = 4'h4;
    fill_valid = with_fill; fill_vpn = fvpn; fill_frame = 20'h13579;
    fdw = 1; fdu = 1; fpw = 1; fpu = 1; fpd = 1; fpg = 0;
    #2;
    chk("R12", {30'd0, lk_hit, lk_fault}, 32'd0);
    chk("R12", {31'd0, lk_miss}, 32'd1);
    @(posedge clk); #1 flush_valid = 0; lk_valid = 0; fill_valid = 0;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look("R1", 32'h0040_1123, 4'h4, 0, 0, 0);
    look("R1", 32'h0000_0000, 4'h2, 0, 0, 0);

    fill(20'h00401, 20'h12345, 1, 1, 1, 1, 1, 0);
    fill(20'h00802, 20'h0ABCD, 1, 0, 1, 1, 1, 0);
    fill(20'h00C03, 20'h77777, 1, 1, 0, 1, 0, 0);
    fill(20'h01004, 20'h55555, 1, 1, 1, 1, 0, 1);
    for (int i = 0; i < NV; i++)
      look(VREQ[i], VEC[i].la, VEC[i].acc, VEC[i].hit, VEC[i].flt, VEC[i].pa);

    // R7: pointer wrapped to slot 0, so page 00401 is evicted
    fill(20'h01405, 20'h22222, 1, 1, 1, 1, 1, 0);
    look("R7", 32'h0040_1000, 4'h4, 0, 0, 0);
    look("R7", 32'h0140_5ABC, 4'h4, 1, 0, 32'h2222_2ABC);
    // R8: refill present page with new frame and dirty set; pointer stays
    fill(20'h01004, 20'h66666, 1, 1, 1, 1, 1, 1);
    look("R8", 32'h0100_4321, 4'h5, 1, 0, 32'h6666_6321);
    fill(20'h01806, 20'h33333, 1, 1, 1, 1, 1, 0);
    look("R8", 32'h0080_2000, 4'h2, 0, 0, 0);
    look("R8", 32'h00C0_3000, 4'h4, 1, 0, 32'h7777_7000);
    look("R7", 32'h0180_6001, 4'h4, 1, 0, 32'h3333_3001);

    // R9
    inval(20'h00C03, 0, 20'h0);
    look("R9", 32'h00C0_3000, 4'h4, 0, 0, 0);
    look("R9", 32'h0100_4000, 4'h4, 1, 0, 32'h6666_6000);
    look("R9", 32'h0140_5000, 4'h4, 1, 0, 32'h2222_2000);
    // R13: fill alongside invalidate is discarded
    inval(20'h01405, 1, 20'h01C07);
    look("R13", 32'h0140_5000, 4'h4, 0, 0, 0);
    look("R13", 32'h01C0_7000, 4'h4, 0, 0, 0);

    // R10 (and R12 via lookup in flush cycle)
    flush(0, 32'h0100_4000, 0, 20'h0);
    look("R10", 32'h0100_4010, 4'h4, 1, 0, 32'h6666_6010);
    look("R10", 32'h0180_6000, 4'h4, 0, 0, 0);
    // R11, with a fill in the flush cycle discarded (R13)
    flush(1, 32'h0100_4000, 1, 20'h01C07);
    look("R11", 32'h0100_4010, 4'h4, 0, 0, 0);
    look("R13", 32'h01C0_7000, 4'h4, 0, 0, 0);

    // R1: reset in mid-use clears everything
    @(negedge clk); rst_n = 0;
    fill(20'h00401, 20'h12345, 1, 1, 1, 1, 1, 0);
    @(negedge clk); rst_n = 1;
    look("R1", 32'h0040_1000, 4'h4, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule